// File: doc/BRIEF.md
# Flash Step Sequencer

This block runs a short byte-coded program that drives the register interface of a SPI master, so that a flash page can be erased, written or polled without a processor. A host fills a small byte memory with the program and pulses `start`. The sequencer then fetches opcodes from address 0 upward and turns each step into register reads and writes. These steps are: pushing bytes into the transmit queue, waiting for the transmit watermark, writing a control register, changing the direction field of the frame format, and polling the flash status until the busy bit clears. The program ends with an exit opcode, which raises `done` for one cycle. An opcode that is not recognised, or a poll that outlasts `timeout_limit`, raises `error` for one cycle instead.

The controller is a single state machine. Its states are IDLE, FETCH_OP, OPCODE, FETCH_ARG, ARG, TXQ_RD, TXQ_WR, RXQ_RD, WM_RD, REG_WR, FMT_RD, FMT_WR, DONE and FAIL. The transitions are as follows:
- IDLE moves to FETCH_OP on start.
- FETCH_OP moves to OPCODE, and FETCH_ARG moves to ARG.
- OPCODE goes to DONE on exit, to FETCH_ARG on transmit, write-register or set-direction, to WM_RD on watermark wait, to TXQ_RD on busy wait, and to FAIL on any other value.
- ARG goes back to FETCH_ARG for a further operand, or on to TXQ_RD, REG_WR or FMT_RD.
- TXQ_RD repeats while the queue reports full, then goes to TXQ_WR.
- TXQ_WR goes to RXQ_RD inside a busy wait. Otherwise it goes to FETCH_ARG, or to FETCH_OP after the last byte.
- RXQ_RD repeats while the queue reports empty. It goes back to TXQ_RD while the status byte shows busy, and to FETCH_OP once it does not.
- WM_RD repeats until the watermark is seen, then goes to FETCH_OP.
- REG_WR goes to FETCH_OP, and FMT_RD goes to FMT_WR, which goes to FETCH_OP.
- Any failing poll goes to FAIL once the timeout has expired. DONE and FAIL return to IDLE.

Program memory has a read latency of one cycle. A register access holds `reg_valid` until `reg_ready`, and read data is taken in the cycle where both are high.

Top module: `flash_step_seq`

## Requirements
- R1: A start pulse while idle sets the program counter to 0, and the next cycle fetches address 0. Running the same program twice gives the same bus traffic.
- R2: Exit (opcode 4) raises done for exactly one cycle, after which the block is idle.
- R3: Write-register (opcode 16) takes an offset byte, then a data byte. It performs one write with address equal to the offset and the data zero-extended.
- R4: Transmit (opcode 8) takes a count byte, then that many data bytes. Before each byte is written to address 0x48, the sequencer reads 0x48, and it repeats that read while bit 31 is set.
- R5: Watermark wait (opcode 12) reads address 0x74 until bit 0 is set and performs no writes.
- R6: Set-direction (opcode 24) takes one byte. It reads address 0x40 and writes the value back with bit 3 replaced by bit 3 of the operand. All other bits are kept.
- R7: Busy wait (opcode 20) pushes 0x05 and pops one byte, which it discards. It then pushes 0x00 and pops, repeating until a popped byte has bit 0 clear. Pops read address 0x4C and are repeated while bit 31 is set.
- R8: An opcode outside {4, 8, 12, 16, 20, 24} raises error for one cycle without done, and execution stops.
- R9: When a poll read fails after the poll has run for at least timeout_limit cycles, error is raised. A busy wait is timed as one poll over its whole duration.
- R10: A page-program program produces the exact sequence of writes: write enable, chip-select hold, command, address and data, chip-select release, hold, status polling, release.
- R11: After reset, and whenever idle, busy, done, error, reg_valid and prog_rd are all low.
- R12: A register request stays valid with stable address, data and direction until it is accepted, and it is issued once per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution at address 0 |
| timeout_limit | input | TW | Poll cycle limit |
| prog_rd | output | 1 | Program byte read strobe |
| prog_addr | output | AW | Program byte address |
| prog_rdata | input | 8 | Program byte, valid one cycle after prog_rd |
| reg_valid | output | 1 | Register access request |
| reg_write | output | 1 | 1 for write, 0 for read |
| reg_addr | output | RAW | Register offset |
| reg_wdata | output | DW | Write data |
| reg_ready | input | 1 | Access accepted |
| reg_rdata | input | DW | Read data, valid with reg_ready |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle exit pulse |
| error | output | 1 | One-cycle failure pulse |

## Verification
The bench targets several corner cases and the failure each would expose:
- A transmit queue that reports full for several reads: a sequencer that skips the poll loses or duplicates bytes.
- A receive queue that alternates empty and full: a sequencer that treats an empty pop as status would finish the busy wait early.
- A busy wait whose first status is ready but discarded: a design that checks the discarded byte would stop after the 0x05 push.
- A set-direction operand with every bit but bit 3 set: a sloppy field merge shows up in the written frame format.
- Watermark and busy polls that never succeed: without a step-long timer the run hangs, and a timer that restarts on each byte of the busy loop never fires.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    // opcodes
    localparam logic [7:0] OP_EXIT = 8'd4;
    localparam logic [7:0] OP_TX   = 8'd8;
    localparam logic [7:0] OP_WM   = 8'd12;
    localparam logic [7:0] OP_WREG = 8'd16;
    localparam logic [7:0] OP_BUSY = 8'd20;
    localparam logic [7:0] OP_DIR  = 8'd24;

    // register offsets decoded by the SPI master
    localparam logic [7:0] A_TXQ  = 8'h48;
    localparam logic [7:0] A_RXQ  = 8'h4C;
    localparam logic [7:0] A_PEND = 8'h74;
    localparam logic [7:0] A_FMT  = 8'h40;

    localparam logic [7:0] CMD_STATUS = 8'h05;
    localparam logic [7:0] CMD_FILL   = 8'h00;

    localparam int QFLAG_BIT = 31;
    localparam int WM_BIT    = 0;
    localparam int BSY_BIT   = 0;
    localparam int DIR_BIT   = 3;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH_OP, S_OPCODE, S_FETCH_ARG, S_ARG,
        S_TXQ_RD, S_TXQ_WR, S_RXQ_RD, S_WM_RD, S_REG_WR,
        S_FMT_RD, S_FMT_WR, S_DONE, S_FAIL
    } seq_state_t;

    function automatic logic op_known(input logic [7:0] b);
        return (b == OP_EXIT) || (b == OP_TX) || (b == OP_WM) ||
               (b == OP_WREG) || (b == OP_BUSY) || (b == OP_DIR);
    endfunction

endpackage

// File: rtl/seqr_poll_timer.sv
module seqr_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (run && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/seqr_reg_port.sv
module seqr_reg_port #(
    parameter int RAW = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           req_write,
    input  logic [RAW-1:0] req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic           ready,
    output logic           valid,
    output logic           write,
    output logic [RAW-1:0] addr,
    output logic [DW-1:0]  wdata,
    output logic           xfer
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            write <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else if (valid) begin
            if (ready)
                valid <= 1'b0;
        end else if (req) begin
            valid <= 1'b1;
            write <= req_write;
            addr  <= req_addr;
            wdata <= req_wdata;
        end
    end

    assign xfer = valid && ready;
endmodule

// File: rtl/seqr_fmt_merge.sv
module seqr_fmt_merge #(
    parameter int DW      = 32,
    parameter int FIELD_B = 3
) (
    input  logic [DW-1:0] cur,
    input  logic [7:0]    arg,
    output logic [DW-1:0] merged
);
    localparam logic [DW-1:0] MASK = DW'(1) << FIELD_B;

    logic [DW-1:0] arg_ext;

    always_comb begin
        arg_ext = {{(DW-8){1'b0}}, arg};
        merged  = (cur & ~MASK) | (arg_ext & MASK);
    end
endmodule

// File: rtl/flash_step_seq.sv
module flash_step_seq
    import seqr_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int RAW = 8,
    parameter int TW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [TW-1:0]  timeout_limit,
    output logic           prog_rd,
    output logic [AW-1:0]  prog_addr,
    input  logic [7:0]     prog_rdata,
    output logic           reg_valid,
    output logic           reg_write,
    output logic [RAW-1:0] reg_addr,
    output logic [DW-1:0]  reg_wdata,
    input  logic           reg_ready,
    input  logic [DW-1:0]  reg_rdata,
    output logic           busy,
    output logic           done,
    output logic           error
);
    localparam int PADW = DW - 8;

    seq_state_t state_q, state_d;

    logic [AW-1:0] pc_q;
    logic [7:0]    op_q;
    logic          arg_idx_q;
    logic [7:0]    remain_q;
    logic [7:0]    txb_q;
    logic [7:0]    off_q;
    logic [7:0]    wdat_q;
    logic          first_q;
    logic [DW-1:0] fmt_q;

    logic           acc_req;
    logic           acc_write;
    logic [RAW-1:0] acc_addr;
    logic [DW-1:0]  acc_wdata;
    logic           xfer;
    logic           tmr_clr;
    logic           tmr_run;
    logic           expired;
    logic [DW-1:0]  fmt_new;

    logic q_flag;
    logic wm_set;
    logic flash_bsy;

    assign q_flag    = reg_rdata[QFLAG_BIT];
    assign wm_set    = reg_rdata[WM_BIT];
    assign flash_bsy = reg_rdata[BSY_BIT];

    seqr_reg_port #(.RAW(RAW), .DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (acc_req),
        .req_write (acc_write),
        .req_addr  (acc_addr),
        .req_wdata (acc_wdata),
        .ready     (reg_ready),
        .valid     (reg_valid),
        .write     (reg_write),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .xfer      (xfer)
    );

    seqr_poll_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .limit   (timeout_limit),
        .expired (expired)
    );

    seqr_fmt_merge #(.DW(DW), .FIELD_B(DIR_BIT)) u_merge (
        .cur    (reg_rdata),
        .arg    (wdat_q),
        .merged (fmt_new)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_FETCH_OP;
            S_FETCH_OP:  state_d = S_OPCODE;
            S_OPCODE: begin
                unique case (prog_rdata)
                    OP_EXIT: state_d = S_DONE;
                    OP_TX,
                    OP_WREG,
                    OP_DIR:  state_d = S_FETCH_ARG;
                    OP_WM:   state_d = S_WM_RD;
                    OP_BUSY: state_d = S_TXQ_RD;
                    default: state_d = S_FAIL;
                endcase
            end
            S_FETCH_ARG: state_d = S_ARG;
            S_ARG: begin
                unique case (op_q)
                    OP_TX: begin
                        if (arg_idx_q)
                            state_d = S_TXQ_RD;
                        else if (prog_rdata == 8'd0)
                            state_d = S_FETCH_OP;
                        else
                            state_d = S_FETCH_ARG;
                    end
                    OP_WREG: state_d = arg_idx_q ? S_REG_WR : S_FETCH_ARG;
                    OP_DIR:  state_d = S_FMT_RD;
                    default: state_d = S_FAIL;
                endcase
            end
            S_TXQ_RD: begin
                if (xfer) begin
                    if (!q_flag)
                        state_d = S_TXQ_WR;
                    else if (expired)
                        state_d = S_FAIL;
                end
            end
            S_TXQ_WR: begin
                if (xfer) begin
                    if (op_q == OP_BUSY)
                        state_d = S_RXQ_RD;
                    else if (remain_q == 8'd1)
                        state_d = S_FETCH_OP;
                    else
                        state_d = S_FETCH_ARG;
                end
            end
            S_RXQ_RD: begin
                if (xfer) begin
                    if (q_flag) begin
                        if (expired) state_d = S_FAIL;
                    end else if (first_q) begin
                        state_d = S_TXQ_RD;
                    end else if (flash_bsy) begin
                        state_d = expired ? S_FAIL : S_TXQ_RD;
                    end else begin
                        state_d = S_FETCH_OP;
                    end
                end
            end
            S_WM_RD: begin
                if (xfer) begin
                    if (wm_set)
                        state_d = S_FETCH_OP;
                    else if (expired)
                        state_d = S_FAIL;
                end
            end
            S_REG_WR:    if (xfer) state_d = S_FETCH_OP;
            S_FMT_RD:    if (xfer) state_d = S_FMT_WR;
            S_FMT_WR:    if (xfer) state_d = S_FETCH_OP;
            S_DONE:      state_d = S_IDLE;
            S_FAIL:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q      <= '0;
            op_q      <= '0;
            arg_idx_q <= 1'b0;
            remain_q  <= '0;
            txb_q     <= '0;
            off_q     <= '0;
            wdat_q    <= '0;
            first_q   <= 1'b0;
            fmt_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) pc_q <= '0;
                S_FETCH_OP,
                S_FETCH_ARG: pc_q <= pc_q + 1'b1;
                S_OPCODE: begin
                    op_q      <= prog_rdata;
                    arg_idx_q <= 1'b0;
                    if (prog_rdata == OP_BUSY) begin
                        txb_q   <= CMD_STATUS;
                        first_q <= 1'b1;
                    end
                end
                S_ARG: begin
                    unique case (op_q)
                        OP_TX: begin
                            if (arg_idx_q) begin
                                txb_q <= prog_rdata;
                            end else begin
                                remain_q  <= prog_rdata;
                                arg_idx_q <= 1'b1;
                            end
                        end
                        OP_WREG: begin
                            if (arg_idx_q) begin
                                wdat_q <= prog_rdata;
                            end else begin
                                off_q     <= prog_rdata;
                                arg_idx_q <= 1'b1;
                            end
                        end
                        OP_DIR:  wdat_q <= prog_rdata;
                        default: ;
                    endcase
                end
                S_TXQ_WR: if (xfer && op_q != OP_BUSY) remain_q <= remain_q - 1'b1;
                S_RXQ_RD: begin
                    if (xfer && !q_flag) begin
                        first_q <= 1'b0;
                        txb_q   <= CMD_FILL;
                    end
                end
                S_FMT_RD: if (xfer) fmt_q <= fmt_new;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        prog_rd   = 1'b0;
        prog_addr = pc_q;
        acc_req   = 1'b0;
        acc_write = 1'b0;
        acc_addr  = '0;
        acc_wdata = '0;
        busy      = (state_q != S_IDLE);
        done      = 1'b0;
        error     = 1'b0;
        tmr_run   = 1'b0;
        tmr_clr   = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_FETCH_OP,
            S_FETCH_ARG: prog_rd = 1'b1;
            S_OPCODE: tmr_clr = 1'b1;
            S_ARG: ;
            S_TXQ_RD: begin
                acc_req  = 1'b1;
                acc_addr = RAW'(A_TXQ);
                tmr_run  = 1'b1;
                tmr_clr  = xfer && !q_flag && (op_q != OP_BUSY);
            end
            S_TXQ_WR: begin
                acc_req   = 1'b1;
                acc_write = 1'b1;
                acc_addr  = RAW'(A_TXQ);
                acc_wdata = {{PADW{1'b0}}, txb_q};
                tmr_run   = (op_q == OP_BUSY);
            end
            S_RXQ_RD: begin
                acc_req  = 1'b1;
                acc_addr = RAW'(A_RXQ);
                tmr_run  = 1'b1;
            end
            S_WM_RD: begin
                acc_req  = 1'b1;
                acc_addr = RAW'(A_PEND);
                tmr_run  = 1'b1;
                tmr_clr  = xfer && wm_set;
            end
            S_REG_WR: begin
                acc_req   = 1'b1;
                acc_write = 1'b1;
                acc_addr  = RAW'(off_q);
                acc_wdata = {{PADW{1'b0}}, wdat_q};
            end
            S_FMT_RD: begin
                acc_req  = 1'b1;
                acc_addr = RAW'(A_FMT);
            end
            S_FMT_WR: begin
                acc_req   = 1'b1;
                acc_write = 1'b1;
                acc_addr  = RAW'(A_FMT);
                acc_wdata = fmt_q;
            end
            S_DONE: done  = 1'b1;
            S_FAIL: error = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/seqr_checker.sv
module seqr_checker
    import seqr_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int RAW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           error,
    input logic           prog_rd,
    input logic [AW-1:0]  prog_addr,
    input logic [7:0]     prog_rdata,
    input logic           reg_valid,
    input logic           reg_ready,
    input logic           reg_write,
    input logic [RAW-1:0] reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input seq_state_t     state_q
);
    p_start_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (prog_rd && prog_addr == '0));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OPCODE && !op_known(prog_rdata)) |=> (error && !done));

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) &&
                                       $stable(reg_wdata) && $stable(reg_write)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_valid && !prog_rd && !done && !error));
endmodule

bind flash_step_seq seqr_checker #(.AW(AW), .DW(DW), .RAW(RAW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .prog_rd    (prog_rd),
    .prog_addr  (prog_addr),
    .prog_rdata (prog_rdata),
    .reg_valid  (reg_valid),
    .reg_ready  (reg_ready),
    .reg_write  (reg_write),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .state_q    (state_q)
);

// File: tb/flash_step_seq_test.sv
module flash_step_seq_test;
    localparam int AW = 8, DW = 32, RAW = 8, TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [TW-1:0] timeout_limit = 16'd1000;
    logic prog_rd;
    logic [AW-1:0] prog_addr;
    logic [7:0] prog_rdata = 8'h0;
    logic reg_valid, reg_write;
    logic [RAW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic reg_ready = 1'b0;
    logic [DW-1:0] reg_rdata = '0;
    logic busy, done, error;

    always #2 clk = ~clk;

    flash_step_seq #(.AW(AW), .DW(DW), .RAW(RAW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_limit(timeout_limit),
        .prog_rd(prog_rd), .prog_addr(prog_addr), .prog_rdata(prog_rdata),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .error(error)
    );

    // program memory, one-cycle read
    logic [7:0] mem [0:255];
    always @(posedge clk) if (prog_rd) prog_rdata <= mem[prog_addr];

    // behavioural register responder
    logic [31:0] fmt_m;
    int busy_left, tx_full_left, n_txrd, wl_n;
    bit wm_ok, rx_alt, rx_tog;
    logic [7:0]  wl_a [0:63];
    logic [31:0] wl_d [0:63];

    always @(posedge clk) begin
        reg_ready <= 1'b0;
        if (rst_n && reg_valid && !reg_ready) begin
            reg_ready <= 1'b1;
            if (reg_write) begin
                if (wl_n < 64) begin
                    wl_a[wl_n] <= reg_addr;
                    wl_d[wl_n] <= reg_wdata;
                end
                wl_n <= wl_n + 1;
                if (reg_addr == 8'h40) fmt_m <= reg_wdata;
            end else begin
                case (reg_addr)
                    8'h48: begin
                        n_txrd <= n_txrd + 1;
                        if (tx_full_left > 0) begin
                            reg_rdata <= 32'h8000_0000;
                            tx_full_left <= tx_full_left - 1;
                        end else reg_rdata <= 32'h0;
                    end
                    8'h4C: begin
                        if (rx_alt && !rx_tog) begin
                            reg_rdata <= 32'h8000_0000;
                            rx_tog <= 1'b1;
                        end else begin
                            rx_tog <= 1'b0;
                            reg_rdata <= {31'b0, busy_left != 0};
                            if (busy_left > 0) busy_left <= busy_left - 1;
                        end
                    end
                    8'h74:   reg_rdata <= {31'b0, wm_ok};
                    8'h40:   reg_rdata <= fmt_m;
                    default: reg_rdata <= 32'h0;
                endcase
            end
        end
    end

    int done_cnt, err_cnt;
    always @(negedge clk) begin
        if (done)  done_cnt = done_cnt + 1;
        if (error) err_cnt  = err_cnt + 1;
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < 256; i++) mem[i] = 8'h04;
        fmt_m = 32'h0008_000D;
        busy_left = 0; tx_full_left = 0; n_txrd = 0; wl_n = 0;
        wm_ok = 1'b1; rx_alt = 1'b0; rx_tog = 1'b0;
        done_cnt = 0; err_cnt = 0;
    endtask

    task automatic run_prog(input int limit, output int elapsed);
        timeout_limit = 16'(limit);
        done_cnt = 0; err_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        elapsed = 1;
        while (!(done || error) && elapsed < 20000) begin
            @(negedge clk);
            elapsed++;
        end
        repeat (3) @(negedge clk);
    endtask

    // rows: op, arg0, arg1, writes, last addr, last data
    localparam logic [71:0] VEC [0:5] = '{
        {8'd16, 8'h18, 8'h02, 8'd1, 8'h18, 32'h0000_0002},
        {8'd16, 8'h10, 8'hFF, 8'd1, 8'h10, 32'h0000_00FF},
        {8'd24, 8'hF7, 8'h00, 8'd1, 8'h40, 32'h0008_0005},
        {8'd24, 8'h08, 8'h00, 8'd1, 8'h40, 32'h0008_000D},
        {8'd8,  8'h01, 8'hA5, 8'd1, 8'h48, 32'h0000_00A5},
        {8'd12, 8'h00, 8'h00, 8'd0, 8'h00, 32'h0000_0000}
    };

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'd16:   return "R3";
            8'd24:   return "R6";
            8'd8:    return "R4";
            default: return "R5";
        endcase
    endfunction

    logic [7:0]  exp_a [0:31];
    logic [31:0] exp_d [0:31];
    int exp_n;

    task automatic push_exp(input logic [7:0] a, input logic [31:0] d);
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
    endtask

    task automatic load_page_prog();
        logic [7:0] p [0:25];
        p = '{8'd8, 8'd1, 8'h06, 8'd12, 8'd16, 8'h18, 8'h02,
              8'd8, 8'd8, 8'h02, 8'h12, 8'h34, 8'h56, 8'hD0, 8'hD1, 8'hD2, 8'hD3,
              8'd12, 8'd16, 8'h18, 8'h00, 8'd16, 8'h18, 8'h02, 8'd20, 8'd16};
        for (int i = 0; i < 26; i++) mem[i] = p[i];
        mem[26] = 8'h18; mem[27] = 8'h00; mem[28] = 8'd4;
        exp_n = 0;
        push_exp(8'h48, 32'h06); push_exp(8'h18, 32'h02);
        push_exp(8'h48, 32'h02); push_exp(8'h48, 32'h12);
        push_exp(8'h48, 32'h34); push_exp(8'h48, 32'h56);
        push_exp(8'h48, 32'hD0); push_exp(8'h48, 32'hD1);
        push_exp(8'h48, 32'hD2); push_exp(8'h48, 32'hD3);
        push_exp(8'h18, 32'h00); push_exp(8'h18, 32'h02);
        push_exp(8'h48, 32'h05);
        for (int i = 0; i < 3; i++) push_exp(8'h48, 32'h00);
        push_exp(8'h18, 32'h00);
    endtask

    task automatic cmp_log(input string req);
        chk(wl_n == exp_n, req, wl_n, exp_n);
        for (int i = 0; i < exp_n && i < wl_n; i++)
            chk(wl_a[i] == exp_a[i] && wl_d[i] == exp_d[i], req,
                {wl_a[i], wl_d[i]}, {exp_a[i], exp_d[i]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int el;
        prep();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !error, "R11", {busy, done, error}, 0);
        chk(!reg_valid && !prog_rd, "R11", {reg_valid, prog_rd}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !reg_valid, "R11", {busy, reg_valid}, 0);

        // vector table: single-step programs
        for (int i = 0; i < 6; i++) begin
            logic [71:0] v;
            v = VEC[i];
            prep();
            mem[0] = v[71:64];
            case (v[71:64])
                8'd16, 8'd8: begin mem[1] = v[63:56]; mem[2] = v[55:48]; mem[3] = 8'd4; end
                8'd24:       begin mem[1] = v[63:56]; mem[2] = 8'd4; end
                default:     mem[1] = 8'd4;
            endcase
            run_prog(1000, el);
            chk(done_cnt == 1 && err_cnt == 0, "R2", {done_cnt, err_cnt}, 64'h1_0000_0000);
            chk(wl_n == int'(v[47:40]), req_of(v[71:64]), wl_n, v[47:40]);
            if (wl_n > 0)
                chk(wl_a[wl_n-1] == v[39:32] && wl_d[wl_n-1] == v[31:0], req_of(v[71:64]),
                    {wl_a[wl_n-1], wl_d[wl_n-1]}, v[39:0]);
        end

        // R10 page program, R7 busy wait with three busy statuses, R12 single issue
        prep();
        load_page_prog();
        busy_left = 3;
        run_prog(1000, el);
        chk(done_cnt == 1 && err_cnt == 0, "R10", {done_cnt, err_cnt}, 64'h1_0000_0000);
        cmp_log("R10");
        chk(wl_n == 17, "R12", wl_n, 17);

        // R1 restart from address 0 gives identical traffic
        wl_n = 0; busy_left = 3;
        run_prog(1000, el);
        cmp_log("R1");

        // R4 transmit queue reports full three times
        prep();
        mem[0] = 8'd8; mem[1] = 8'd2; mem[2] = 8'h11; mem[3] = 8'h22;
        tx_full_left = 3;
        run_prog(1000, el);
        chk(n_txrd == 5, "R4", n_txrd, 5);
        exp_n = 0; push_exp(8'h48, 32'h11); push_exp(8'h48, 32'h22);
        cmp_log("R4");

        // R7 first status ready but discarded, empty pops interleaved
        prep();
        mem[0] = 8'd20;
        rx_alt = 1'b1;
        run_prog(1000, el);
        exp_n = 0; push_exp(8'h48, 32'h05); push_exp(8'h48, 32'h00);
        cmp_log("R7");

        // R7 five busy statuses
        prep();
        mem[0] = 8'd20;
        busy_left = 5;
        run_prog(1000, el);
        chk(wl_n == 6 && done_cnt == 1, "R7", wl_n, 6);

        // R8 unknown opcode
        prep();
        mem[0] = 8'h33;
        run_prog(1000, el);
        chk(err_cnt == 1 && done_cnt == 0, "R8", {err_cnt, done_cnt}, 64'h1_0000_0000);
        chk(wl_n == 0 && !busy, "R8", {wl_n, busy}, 0);

        // R9 watermark never set
        prep();
        mem[0] = 8'd12;
        wm_ok = 1'b0;
        run_prog(20, el);
        chk(err_cnt == 1 && done_cnt == 0, "R9", {err_cnt, done_cnt}, 64'h1_0000_0000);
        chk(el >= 20 && el <= 32, "R9", el, 20);

        // R9 flash stays busy: timer spans the whole busy step
        prep();
        mem[0] = 8'd20;
        busy_left = 1000;
        run_prog(60, el);
        chk(err_cnt == 1 && done_cnt == 0, "R9", {err_cnt, done_cnt}, 64'h1_0000_0000);
        chk(!busy && !reg_valid, "R11", {busy, reg_valid}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule